// File: doc/BRIEF.md
# LCD Interrupt Status Aggregator

This block collects the interrupt events of a seven-channel display controller into two sticky status words. Channel 0 and the controller-wide events go to the primary word. Channels 1 and up go to the secondary word. The block combines the status bits with mask bits held in two control words and drives one registered, level-sensitive interrupt line.

When the interrupt line is low, a new unmasked frame event (start of frame, end of frame, branch, bus error) records the frame identifier of its channel in an ID register, so software can see which channel raised the interrupt. When the line is already high, the same event sets a "subsequent interrupt" status bit and leaves the ID register alone. Software clears status bits by writing ones through a small register port. The control words are written through the same port.

Register port address codes: 0 = primary control, 1 = secondary control (mask word), 2 = primary status, 3 = secondary status, 4 = interrupt ID (read only). Any other code reads as zero and ignores writes. Reads are combinational from the addressed register.

Top module: `lcd_irq_agg`

## Requirements
- R1: After reset, every register (both control words, both status words, the ID register) reads zero and `irqOut` is low.
- R2: A primary-control write keeps only bits 26:0. A mask-word write keeps only the bits in 0x3f3f3f3f.
- R3: `irqOut` is recomputed one clock after the registers change. It is high when any primary-status event is set with its mask clear, or when any secondary-status bit is set with the same mask-word bit clear. The primary event/mask pairs are (status bit : control bit): done 0:3, SOF0 1:4, IU0 4:5, OU 6:21, QD 7:11, EOF0 8:6, BS0 9:20, RDST 11:23, CMD 12:24. IU1 (status bit 5) is masked by mask-word bit 24.
- R4: A primary-control write that takes bit 0 from 1 to 0 sets primary-status bit 7.
- R5: Start-of-frame and end-of-frame events are recorded only when the channel's command-enable input for that event is high. Branch events are always recorded. Channel 0 uses primary bits 1 (SOF), 8 (EOF) and 9 (branch). Channel c ≥ 1 uses secondary bits c−1, c+7 and c+15. The mask-word bits for these events sit at the same positions.
- R6: If `irqOut` is low, an unmasked frame event loads the ID register with that channel's frame ID. When several such events arrive in one cycle, the lowest-numbered channel wins.
- R7: If `irqOut` is high, an unmasked frame event sets primary bit 10 and leaves the ID register unchanged.
- R8: A masked frame event only sets its status bit. It neither loads the ID register nor sets bit 10.
- R9: A bus error sets primary bit 2 and writes the channel number into bits 30:28, taking the lowest channel if several arrive together. No mask applies to it, and it follows the R6/R7 rule.
- R10: A read-status event sets primary bit 11 and never loads the ID register. It sets bit 10 only when `irqOut` is high and control bit 23 is clear.
- R11: Writing the primary status clears the bits written as one within bits 11:0. Writing bit 2 as one also clears bits 30:28. Writing the secondary status clears the written-one bits within 0x3e3f3f. All other status bits stay set.
- R12: When a status bit is cleared and set by an event in the same cycle, the event wins.
- R13: The remaining event inputs set their own bits: done → bit 0, AC-bias → bit 3, underrun channel 0 → bit 4, underrun 1 → bit 5, output underrun → bit 6, command → bit 12, and underrun of channel c ≥ 1 → secondary bit c+23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address code |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of addressed register |
| sofEv | input | NCH | Start-of-frame pulse per channel |
| eofEv | input | NCH | End-of-frame pulse per channel |
| sofCmdEn | input | NCH | Command word allows SOF recording |
| eofCmdEn | input | NCH | Command word allows EOF recording |
| branchEv | input | NCH | Branch-taken pulse per channel |
| busErrEv | input | NCH | Bus error pulse per channel |
| chUnderEv | input | NCH | Input underrun pulse per channel |
| frameIds | input | NCH*32 | Frame IDs, channel c at bits c*32 +: 32 |
| evDone | input | 1 | Last frame done pulse |
| evAcBias | input | 1 | AC-bias count pulse |
| evUnder1 | input | 1 | Underrun 1 pulse |
| evOutUnder | input | 1 | Output underrun pulse |
| evReadStat | input | 1 | Read-status pulse |
| evCmd | input | 1 | Command interrupt pulse |
| irqOut | output | 1 | Level interrupt request |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled at the clock edge, and that `sofCmdEn`/`eofCmdEn` are stable in any cycle that carries an event. They also assume that no register write targets an address outside the five codes while a check depends on it. The stimulus drives every input shortly after a rising edge and returns each event to zero after one cycle. Wherever the interrupt level matters, the stimulus first brings the status words to a known state by write-one clears. Sticky bits that cannot be cleared are exercised last, so they do not disturb the earlier scenarios.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  localparam int REG_W = 32;
  localparam int ID_W  = 32;
  localparam int CHF_W = 3;   // width of bus-error channel field

  // register address codes
  localparam logic [2:0] ADDR_CTL0  = 3'd0;
  localparam logic [2:0] ADDR_CTL5  = 3'd1;
  localparam logic [2:0] ADDR_STAT0 = 3'd2;
  localparam logic [2:0] ADDR_STAT1 = 3'd3;
  localparam logic [2:0] ADDR_INTID = 3'd4;

  // write keep / clear masks
  localparam logic [REG_W-1:0] CTL0_KEEP = 32'h07ff_ffff;
  localparam logic [REG_W-1:0] CTL5_KEEP = 32'h3f3f_3f3f;
  localparam logic [REG_W-1:0] CLR0_KEEP = 32'h0000_0fff;
  localparam logic [REG_W-1:0] CLR1_KEEP = 32'h003e_3f3f;

  // primary status bit positions
  localparam int S_DONE = 0;
  localparam int S_SOF0 = 1;
  localparam int S_BER  = 2;
  localparam int S_ACB  = 3;
  localparam int S_IU0  = 4;
  localparam int S_IU1  = 5;
  localparam int S_OU   = 6;
  localparam int S_QD   = 7;
  localparam int S_EOF0 = 8;
  localparam int S_BS0  = 9;
  localparam int S_SINT = 10;
  localparam int S_RDST = 11;
  localparam int S_CMD  = 12;
  localparam int S_CHLO = 28;

  // primary control bit positions
  localparam int C_EN    = 0;
  localparam int C_MDONE = 3;
  localparam int C_MSOF  = 4;
  localparam int C_MIU0  = 5;
  localparam int C_MEOF  = 6;
  localparam int C_MQD   = 11;
  localparam int C_MBS   = 20;
  localparam int C_MOU   = 21;
  localparam int C_MRDST = 23;
  localparam int C_MCMD  = 24;
  localparam int M_IU1   = 24;  // in mask word

  // secondary word offsets for channel c >= 1
  localparam int OFS_SOF = -1;
  localparam int OFS_EOF = 7;
  localparam int OFS_BS  = 15;
  localparam int OFS_IU  = 23;

  typedef struct packed {
    logic [REG_W-1:0] set0;
    logic [REG_W-1:0] set1;
    logic [REG_W-1:0] clr0;
    logic [REG_W-1:0] clr1;
    logic             berHit;
    logic [CHF_W-1:0] berCh;
    logic             idLoad;
    logic [ID_W-1:0]  idVal;
    logic             ctl0Wr;
    logic             ctl5Wr;
    logic [REG_W-1:0] wrVal;
  } strobe_t;
endpackage

// File: rtl/lcd_irq_ctrl.sv
module lcd_irq_ctrl
  import lcd_irq_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic                regWr,
  input  logic [2:0]          regAddr,
  input  logic [REG_W-1:0]    regWrData,
  input  logic [NCH-1:0]      sofEv,
  input  logic [NCH-1:0]      eofEv,
  input  logic [NCH-1:0]      sofCmdEn,
  input  logic [NCH-1:0]      eofCmdEn,
  input  logic [NCH-1:0]      branchEv,
  input  logic [NCH-1:0]      busErrEv,
  input  logic [NCH-1:0]      chUnderEv,
  input  logic [NCH*ID_W-1:0] frameIds,
  input  logic                evDone,
  input  logic                evAcBias,
  input  logic                evUnder1,
  input  logic                evOutUnder,
  input  logic                evReadStat,
  input  logic                evCmd,
  input  logic                irqQ,
  input  logic                ctlEnable,
  input  logic                rdstMask,
  input  logic [NCH-1:0]      sofMask,
  input  logic [NCH-1:0]      eofMask,
  input  logic [NCH-1:0]      brMask,
  output strobe_t             strb
);
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] sofHit, eofHit, wantId;
  logic [SEL_W-1:0] idSel, berSel;
  logic anyWant;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign sofHit[c] = sofEv[c] & sofCmdEn[c];
    assign eofHit[c] = eofEv[c] & eofCmdEn[c];
    assign wantId[c] = (sofHit[c] & ~sofMask[c]) |
                       (eofHit[c] & ~eofMask[c]) |
                       (branchEv[c] & ~brMask[c]) |
                       busErrEv[c];
  end

  assign anyWant = |wantId;

  // lowest channel wins
  always_comb begin
    idSel  = '0;
    berSel = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (wantId[c])   idSel  = SEL_W'(c);
      if (busErrEv[c]) berSel = SEL_W'(c);
    end
  end

  always_comb begin
    strb        = '0;
    strb.wrVal  = regWrData;
    strb.ctl0Wr = regWr && (regAddr == ADDR_CTL0);
    strb.ctl5Wr = regWr && (regAddr == ADDR_CTL5);
    if (regWr && (regAddr == ADDR_STAT0)) strb.clr0 = regWrData & CLR0_KEEP;
    if (regWr && (regAddr == ADDR_STAT1)) strb.clr1 = regWrData & CLR1_KEEP;

    strb.set0[S_DONE] = evDone;
    strb.set0[S_SOF0] = sofHit[0];
    strb.set0[S_BER]  = |busErrEv;
    strb.set0[S_ACB]  = evAcBias;
    strb.set0[S_IU0]  = chUnderEv[0];
    strb.set0[S_IU1]  = evUnder1;
    strb.set0[S_OU]   = evOutUnder;
    strb.set0[S_QD]   = strb.ctl0Wr && ctlEnable && !regWrData[C_EN];
    strb.set0[S_EOF0] = eofHit[0];
    strb.set0[S_BS0]  = branchEv[0];
    strb.set0[S_RDST] = evReadStat;
    strb.set0[S_CMD]  = evCmd;
    strb.set0[S_SINT] = (anyWant && irqQ) ||
                        (evReadStat && irqQ && !rdstMask);

    for (int c = 1; c < NCH; c++) begin
      strb.set1[c + OFS_SOF] = sofHit[c];
      strb.set1[c + OFS_EOF] = eofHit[c];
      strb.set1[c + OFS_BS]  = branchEv[c];
      strb.set1[c + OFS_IU]  = chUnderEv[c];
    end

    strb.berHit = |busErrEv;
    strb.berCh  = CHF_W'(berSel);
    strb.idLoad = anyWant && !irqQ;
    strb.idVal  = frameIds[idSel*ID_W +: ID_W];
  end
endmodule

// File: rtl/lcd_irq_dpath.sv
module lcd_irq_dpath
  import lcd_irq_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [2:0]       regAddr,
  output logic [REG_W-1:0] regRdData,
  output logic             irqQ,
  output logic             ctlEnable,
  output logic             rdstMask,
  output logic [NCH-1:0]   sofMask,
  output logic [NCH-1:0]   eofMask,
  output logic [NCH-1:0]   brMask
);
  logic [REG_W-1:0] ctl0Q, ctl5Q, stat0Q, stat1Q;
  logic [ID_W-1:0]  idQ;
  logic [REG_W-1:0] stat0Nxt;
  logic             level;

  assign ctlEnable = ctl0Q[C_EN];
  assign rdstMask  = ctl0Q[C_MRDST];

  for (genvar c = 0; c < NCH; c++) begin : g_mask
    if (c == 0) begin : g_base
      assign sofMask[c] = ctl0Q[C_MSOF];
      assign eofMask[c] = ctl0Q[C_MEOF];
      assign brMask[c]  = ctl0Q[C_MBS];
    end else begin : g_ext
      assign sofMask[c] = ctl5Q[c + OFS_SOF];
      assign eofMask[c] = ctl5Q[c + OFS_EOF];
      assign brMask[c]  = ctl5Q[c + OFS_BS];
    end
  end

  always_comb begin
    stat0Nxt = (stat0Q & ~strb.clr0) | strb.set0;
    if (strb.berHit)
      stat0Nxt[S_CHLO +: CHF_W] = strb.berCh;
    else if (strb.clr0[S_BER])
      stat0Nxt[S_CHLO +: CHF_W] = '0;
  end

  assign level =
      (stat0Q[S_DONE] & ~ctl0Q[C_MDONE]) |
      (stat0Q[S_SOF0] & ~ctl0Q[C_MSOF])  |
      (stat0Q[S_IU0]  & ~ctl0Q[C_MIU0])  |
      (stat0Q[S_IU1]  & ~ctl5Q[M_IU1])   |
      (stat0Q[S_OU]   & ~ctl0Q[C_MOU])   |
      (stat0Q[S_QD]   & ~ctl0Q[C_MQD])   |
      (stat0Q[S_EOF0] & ~ctl0Q[C_MEOF])  |
      (stat0Q[S_BS0]  & ~ctl0Q[C_MBS])   |
      (stat0Q[S_RDST] & ~ctl0Q[C_MRDST]) |
      (stat0Q[S_CMD]  & ~ctl0Q[C_MCMD])  |
      (|(stat1Q & ~ctl5Q));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl0Q  <= '0;
      ctl5Q  <= '0;
      stat0Q <= '0;
      stat1Q <= '0;
      idQ    <= '0;
      irqQ   <= 1'b0;
    end else begin
      if (strb.ctl0Wr) ctl0Q <= strb.wrVal & CTL0_KEEP;
      if (strb.ctl5Wr) ctl5Q <= strb.wrVal & CTL5_KEEP;
      stat0Q <= stat0Nxt;
      stat1Q <= (stat1Q & ~strb.clr1) | strb.set1;
      if (strb.idLoad) idQ <= strb.idVal;
      irqQ <= level;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTL0:  regRdData = ctl0Q;
      ADDR_CTL5:  regRdData = ctl5Q;
      ADDR_STAT0: regRdData = stat0Q;
      ADDR_STAT1: regRdData = stat1Q;
      ADDR_INTID: regRdData = idQ;
      default:    regRdData = '0;
    endcase
  end

  // R3: empty status words give a low line on the next cycle
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (stat0Q == '0 && stat1Q == '0) |=> !irqQ);

  // R4: enable falling through a write raises quick-disable
  a_r4_quick_disable: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctl0Wr && ctl0Q[C_EN] && !strb.wrVal[C_EN]) |=> stat0Q[S_QD]);

  // R6: ID register moves only while the line was low
  a_r6_id_when_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(idQ) |-> !$past(irqQ));

  // R7: subsequent-interrupt bit rises only while the line was high
  a_r7_sint_when_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat0Q[S_SINT]) |-> $past(irqQ));

  // R9: bus error records flag and channel
  a_r9_ber_record: assert property (@(posedge clk) disable iff (!rstN)
    strb.berHit |=> (stat0Q[S_BER] &&
                     stat0Q[S_CHLO +: CHF_W] == $past(strb.berCh)));

  // R11: without a status write, no primary bit drops
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clr0 == '0) |=> ((stat0Q[S_CMD:0] & $past(stat0Q[S_CMD:0]))
                           == $past(stat0Q[S_CMD:0])));
endmodule

// File: rtl/lcd_irq_agg.sv
module lcd_irq_agg
  import lcd_irq_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [2:0]          regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [NCH-1:0]      sofEv,
  input  logic [NCH-1:0]      eofEv,
  input  logic [NCH-1:0]      sofCmdEn,
  input  logic [NCH-1:0]      eofCmdEn,
  input  logic [NCH-1:0]      branchEv,
  input  logic [NCH-1:0]      busErrEv,
  input  logic [NCH-1:0]      chUnderEv,
  input  logic [NCH*ID_W-1:0] frameIds,
  input  logic                evDone,
  input  logic                evAcBias,
  input  logic                evUnder1,
  input  logic                evOutUnder,
  input  logic                evReadStat,
  input  logic                evCmd,
  output logic                irqOut
);
  strobe_t        strb;
  logic           irqQ, ctlEnable, rdstMask;
  logic [NCH-1:0] sofMask, eofMask, brMask;

  lcd_irq_ctrl #(.NCH(NCH)) u_ctrl (
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .sofEv(sofEv), .eofEv(eofEv), .sofCmdEn(sofCmdEn), .eofCmdEn(eofCmdEn),
    .branchEv(branchEv), .busErrEv(busErrEv), .chUnderEv(chUnderEv),
    .frameIds(frameIds), .evDone(evDone), .evAcBias(evAcBias),
    .evUnder1(evUnder1), .evOutUnder(evOutUnder), .evReadStat(evReadStat),
    .evCmd(evCmd), .irqQ(irqQ), .ctlEnable(ctlEnable), .rdstMask(rdstMask),
    .sofMask(sofMask), .eofMask(eofMask), .brMask(brMask), .strb(strb)
  );

  lcd_irq_dpath #(.NCH(NCH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regRdData(regRdData), .irqQ(irqQ), .ctlEnable(ctlEnable),
    .rdstMask(rdstMask), .sofMask(sofMask), .eofMask(eofMask),
    .brMask(brMask)
  );

  assign irqOut = irqQ;

  initial begin
    a_r9_field_fits: assert (NCH >= 1 && NCH <= 7);
  end
endmodule

// File: tb/tb_lcd_irq_agg.sv
module tb_lcd_irq_agg;
  localparam int NCH = 7;
  localparam int IDW = 32;

  logic clk = 0, rstN = 0;
  logic regWr = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic [NCH-1:0] sofEv = 0, eofEv = 0, sofCmdEn = 0, eofCmdEn = 0;
  logic [NCH-1:0] branchEv = 0, busErrEv = 0, chUnderEv = 0;
  logic [NCH*IDW-1:0] frameIds;
  logic evDone = 0, evAcBias = 0, evUnder1 = 0, evOutUnder = 0;
  logic evReadStat = 0, evCmd = 0;
  logic irqOut;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] idOf(int c);
    return 32'hA000_0000 + 32'(c) * 32'h11;
  endfunction

  initial for (int c = 0; c < NCH; c++) frameIds[c*IDW +: IDW] = idOf(c);

  lcd_irq_agg #(.NCH(NCH)) dut (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chkReg(string tag, logic [2:0] a, logic [31:0] exp);
    regAddr = a; #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic chkIrq(string tag, logic exp);
    tick();
    chk(tag, {31'd0, irqOut}, {31'd0, exp});
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    regWr = 1; regAddr = a; regWrData = d;
    tick();
    regWr = 0;
  endtask

  task automatic stepEv();
    tick();
    sofEv = 0; eofEv = 0; branchEv = 0; busErrEv = 0; chUnderEv = 0;
    evDone = 0; evAcBias = 0; evUnder1 = 0; evOutUnder = 0;
    evReadStat = 0; evCmd = 0; regWr = 0;
  endtask

  task automatic tReset();
    for (int a = 0; a < 5; a++) chkReg("R1 reset reg", 3'(a), 0);
    chk("R1 reset irq", {31'd0, irqOut}, 0);
  endtask

  task automatic tControl();
    wr(0, 32'hFFFF_FFFF);
    chkReg("R2 ctl0 keep", 0, 32'h07FF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    chkReg("R2 ctl5 keep", 1, 32'h3F3F_3F3F);
    wr(1, 0);
    wr(0, 0);
    chkReg("R4 quick disable", 2, 32'h80);
    chkIrq("R3 qd unmasked irq", 1);
    wr(2, 32'h80);
    chkReg("R11 clear qd", 2, 0);
    chkIrq("R3 irq drops", 0);
  endtask

  task automatic tFrame();
    sofEv[0] = 1; stepEv();
    chkReg("R5 sof without cmd", 2, 0);
    chkReg("R5 id untouched", 4, 0);
    chkIrq("R5 irq stays low", 0);
    sofCmdEn = '1; eofCmdEn = '1;
    sofEv[0] = 1; stepEv();
    chkReg("R5 sof0 bit", 2, 32'h2);
    chkReg("R6 id ch0", 4, idOf(0));
    chkIrq("R3 sof0 irq", 1);
    wr(2, 32'h2);
    chkIrq("R3 cleared", 0);
    eofEv[3] = 1; stepEv();
    chkReg("R5 eof ch3 bit", 3, 32'h400);
    chkReg("R6 id ch3", 4, idOf(3));
    chkIrq("R3 secondary irq", 1);
  endtask

  task automatic tSubsequent();
    branchEv[2] = 1; stepEv();
    chkReg("R5 branch ch2", 3, 32'h2_0400);
    chkReg("R7 sint set", 2, 32'h400);
    chkReg("R7 id held", 4, idOf(3));
    wr(3, 32'h3e_3f3f);
    wr(2, 32'h400);
    chkReg("R11 stat1 clear", 3, 0);
    chkIrq("R3 low again", 0);
  endtask

  task automatic tPriority();
    sofEv[4] = 1; eofEv[1] = 1; stepEv();
    chkReg("R6 two events", 3, 32'h108);
    chkReg("R6 lowest channel", 4, idOf(1));
    chkReg("R6 no sint", 2, 0);
    wr(3, 32'h108);
    chkIrq("R3 low", 0);
  endtask

  task automatic tMasked();
    wr(1, 32'h10);
    sofEv[5] = 1; stepEv();
    chkReg("R8 masked status", 3, 32'h10);
    chkReg("R8 id held", 4, idOf(1));
    chkReg("R8 no sint", 2, 0);
    chkIrq("R8 irq low", 0);
    wr(1, 0);
    chkIrq("R3 unmask raises", 1);
    wr(3, 32'h10);
    chkIrq("R3 low", 0);
  endtask

  task automatic tBusErr();
    busErrEv[6] = 1; busErrEv[3] = 0; stepEv();
    chkReg("R9 ber ch6", 2, 32'h6000_0004);
    chkReg("R9 id ch6", 4, idOf(6));
    chkIrq("R9 ber not in irq", 0);
    wr(2, 32'h4);
    chkReg("R11 ber field clr", 2, 0);
    branchEv[0] = 1; stepEv();
    chkReg("R6 id ch0 branch", 4, idOf(0));
    chkIrq("R3 bs0 irq", 1);
    busErrEv[5] = 1; stepEv();
    chkReg("R9 ber while high", 2, 32'h5000_0604);
    chkReg("R9 id held", 4, idOf(0));
    wr(2, 32'hFFF);
    chkReg("R11 clear all", 2, 0);
    chkIrq("R3 low", 0);
  endtask

  task automatic tReadStat();
    evReadStat = 1; stepEv();
    chkReg("R10 rdst low", 2, 32'h800);
    chkReg("R10 id held", 4, idOf(0));
    chkIrq("R3 rdst irq", 1);
    evReadStat = 1; stepEv();
    chkReg("R10 sint when high", 2, 32'hC00);
    wr(2, 32'hC00);
    wr(0, 32'h0080_0000);
    evOutUnder = 1; stepEv();
    chkIrq("R3 ou irq", 1);
    evReadStat = 1; stepEv();
    chkReg("R10 masked no sint", 2, 32'h840);
    wr(2, 32'h840);
    wr(0, 0);
    chkIrq("R3 low", 0);
  endtask

  task automatic tClearRace();
    evOutUnder = 1; stepEv();
    evOutUnder = 1; regWr = 1; regAddr = 2; regWrData = 32'h40; stepEv();
    chkReg("R12 event beats clear", 2, 32'h40);
    wr(2, 32'h40);
    chkReg("R12 later clear", 2, 0);
    chkIrq("R3 low", 0);
  endtask

  task automatic tMisc();
    evDone = 1; evAcBias = 1; chUnderEv[0] = 1; evUnder1 = 1;
    evCmd = 1; chUnderEv[2] = 1; stepEv();
    chkReg("R13 primary events", 2, 32'h1039);
    chkReg("R13 ch2 underrun", 3, 32'h0200_0000);
    chkIrq("R3 misc irq", 1);
    branchEv[1] = 1; stepEv();
    chkReg("R7 sint via ch1", 2, 32'h1439);
    wr(3, 32'hFFFF_FFFF);
    chkReg("R11 stat1 sticky bits", 3, 32'h0201_0000);
    wr(2, 32'hFFFF_FFFF);
    chkReg("R11 stat0 bit12 sticky", 2, 32'h1000);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    tReset();
    tControl();
    tFrame();
    tSubsequent();
    tPriority();
    tMasked();
    tBusErr();
    tReadStat();
    tClearRace();
    tMisc();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule